// File: doc/BRIEF.md
# Steerable Interrupt Controller with Critical Vector

This block gathers up to 32 interrupt request lines into two processor-facing outputs, a normal interrupt and a critical interrupt. Each request line is synchronised to the block clock and may be inverted. Each line can capture edges or track a level, and can be routed to either output. Software works the block through a word-addressed port with one-cycle read and write strobes. The pending-status word has two write aliases: one clears the bits written as ones, the other sets them.

For the critical output, an optional vector generator picks the pending critical line with the highest priority. The scan direction is programmable. It forms a handler address from a software base plus a fixed stride of 512 bytes for each priority step, so the handler can be entered without a software search. Both outputs and the vector are computed from register state every cycle and then registered.

Top module: `steer_intc`

## Requirements
- R1: After a synchronous active-low reset, every register (enable, critical select, polarity, trigger type, status, vector configuration, vector) reads 0 and both interrupt outputs are low.
- R2: Request line n is reported in register bit (31 − n), so line 0 occupies the most significant bit of every per-source register.
- R3: A source whose trigger-type bit (offset 5) is 1 sets its status bit on a rising edge of its polarity-adjusted input, and the bit stays set after the input falls until software clears it.
- R4: A source whose trigger-type bit is 0 has a status bit that follows its polarity-adjusted input, both rising and falling.
- R5: A write to offset 0 clears every status bit written as 1, then sets again the bits of level-type sources whose adjusted input is still high.
- R6: A write to offset 1 ORs the written word into status, and a level-type bit set this way stays set until its input changes; offsets 0 and 1 both read the status word.
- R7: A polarity bit (offset 4) of 1 inverts its request line before capture, so a low input counts as asserted.
- R8: The normal output is high when status AND enable (offset 2) AND NOT critical-select (offset 3) is nonzero. The critical output is high when status AND enable AND critical-select is nonzero. Both are registered from the status word.
- R9: Offset 6 reads status AND enable. Writes to offsets 6 and 7 change nothing. Offsets 9 to 15 read 0 and ignore writes.
- R10: With vector configuration (offset 8) bit 0 clear, the vector (offset 7) equals (configuration AND 0xFFFFFFFC) plus 512 × the index of the lowest set bit of status AND enable AND critical-select.
- R11: With configuration bit 0 set, the vector uses the highest set bit i of that word, and the offset is (31 − i) × 512.
- R12: The vector reads 0 whenever no critical source is pending, and a configuration write stores the value with bit 1 forced to 0.
- R13: Read data appears on the data output one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Asynchronous interrupt request lines, line n on bit n |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_en | input | 1 | Write strobe, one cycle |
| addr | input | 4 | Word offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq_o | output | 1 | Normal interrupt request |
| crit_irq_o | output | 1 | Critical interrupt request |

## Verification
The hardest states to reach from the ports involve history. One is an edge-type bit that must stay set after its input falls. Another is a level-type bit that must come back after a clear write because its input is still high. A third is a level-type bit set by the software alias that must survive until its input moves. The stimulus reaches these states by mixing random polarity flips, trigger-type rewrites, set and clear writes and sparse input toggles, with a settling gap after each step. A reference model that keeps the previous adjusted input level tracks the history. Directed cases then place pending critical sources at known indices and check the vector in both scan directions, for both the lowest and the highest pending index.

// File: rtl/steer_intc_pkg.sv
// Package: register offsets and shared constants for the steerable
// interrupt controller. Assumes a 4-bit word offset on the access port.
package steer_intc_pkg;

    localparam int OFF_W = 4;

    typedef enum logic [OFF_W-1:0] {
        OFF_CLR  = 4'd0,
        OFF_SET  = 4'd1,
        OFF_EN   = 4'd2,
        OFF_CRIT = 4'd3,
        OFF_POL  = 4'd4,
        OFF_TRIG = 4'd5,
        OFF_MASK = 4'd6,
        OFF_VEC  = 4'd7,
        OFF_VCFG = 4'd8
    } reg_off_e;

endpackage

// File: rtl/intc_capture.sv
// Module: input capture. Synchronises each request line through STAGES
// flops, maps line n to bit (DW-1-n), applies polarity, and reports the
// adjusted level plus rising-edge and change strobes against the previous
// cycle. Assumes STAGES >= 2 and that src_i is asynchronous to clk.
module intc_capture #(
    parameter int DW     = 32,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] pol,
    output logic [DW-1:0] adj,
    output logic [DW-1:0] rise,
    output logic [DW-1:0] chg
);

    logic [DW-1:0] raw;
    logic [DW-1:0] adj_q;

    for (genvar n = 0; n < DW; n++) begin : g_sync
        logic [STAGES-1:0] sh;
        // Shift the request line through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], src_i[n]};
        end
        assign raw[DW-1-n] = sh[STAGES-1];
    end

    assign adj = raw ^ pol;

    // Remember the adjusted level of the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) adj_q <= '0;
        else        adj_q <= adj;
    end

    assign rise = adj & ~adj_q;
    assign chg  = adj ^ adj_q;

endmodule

// File: rtl/intc_vector.sv
// Module: critical vector generator. Scans the pending-critical word for
// the lowest (cfg[0]=0) or highest (cfg[0]=1) set bit and forms
// base + step << STRIDE_LOG2, where step counts from the scan start.
// Returns 0 when nothing is pending. Purely combinational.
module intc_vector #(
    parameter int DW          = 32,
    parameter int STRIDE_LOG2 = 9
) (
    input  logic [DW-1:0] pend,
    input  logic [DW-1:0] cfg,
    output logic [DW-1:0] vec
);

    localparam int IW = $clog2(DW);

    logic [IW-1:0] lo_idx;
    logic [IW-1:0] hi_idx;
    logic [IW-1:0] step;

    // Priority scans from both ends of the pending word.
    always_comb begin
        lo_idx = '0;
        hi_idx = '0;
        for (int i = DW-1; i >= 0; i--) begin
            if (pend[i]) lo_idx = IW'(i);
        end
        for (int i = 0; i < DW; i++) begin
            if (pend[i]) hi_idx = IW'(i);
        end
    end

    // Select the step count for the programmed direction and build the address.
    always_comb begin
        step = cfg[0] ? (IW'(DW-1) - hi_idx) : lo_idx;
        if (|pend) vec = {cfg[DW-1:2], 2'b00} + (DW'(step) << STRIDE_LOG2);
        else       vec = '0;
    end

endmodule

// File: rtl/steer_intc.sv
// Module: top of the steerable interrupt controller. Holds the register
// file, updates the status word from software writes and captured input
// events, and registers both outputs, the vector and the read data.
// Assumes one access per cycle (rd_en and wr_en never both high).
module steer_intc
    import steer_intc_pkg::*;
#(
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2,
    parameter int STRIDE_LOG2 = 9,
    parameter bit VEC_EN      = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    src_i,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             irq_o,
    output logic             crit_irq_o
);

    logic [DW-1:0] st_q, st_n;
    logic [DW-1:0] en_q, crit_q, pol_q, trig_q, vcfg_q;
    logic [DW-1:0] vec_q, vec_c;
    logic [DW-1:0] adj, rise, chg;
    logic [DW-1:0] pend_nrm, pend_crit;
    logic [DW-1:0] rd_mux;

    intc_capture #(.DW(DW), .STAGES(SYNC_STAGES)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_i),
        .pol   (pol_q),
        .adj   (adj),
        .rise  (rise),
        .chg   (chg)
    );

    assign pend_nrm  = st_q & en_q & ~crit_q;
    assign pend_crit = st_q & en_q & crit_q;

    if (VEC_EN) begin : g_vec
        intc_vector #(.DW(DW), .STRIDE_LOG2(STRIDE_LOG2)) u_vec (
            .pend (pend_crit),
            .cfg  (vcfg_q),
            .vec  (vec_c)
        );
    end else begin : g_novec
        assign vec_c = '0;
    end

    // Next status: software alias first, then edge sets and level tracking.
    always_comb begin
        st_n = st_q;
        if (wr_en && addr == OFF_CLR)      st_n = (st_q & ~wdata) | (adj & ~trig_q);
        else if (wr_en && addr == OFF_SET) st_n = st_q | wdata;
        st_n = st_n | (rise & trig_q);
        st_n = (st_n & ~(chg & ~trig_q)) | (adj & chg & ~trig_q);
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_n;
    end

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            crit_q <= '0;
            pol_q  <= '0;
            trig_q <= '0;
            vcfg_q <= '0;
        end else if (wr_en) begin
            case (addr)
                OFF_EN:   en_q   <= wdata;
                OFF_CRIT: crit_q <= wdata;
                OFF_POL:  pol_q  <= wdata;
                OFF_TRIG: trig_q <= wdata;
                OFF_VCFG: if (VEC_EN) vcfg_q <= wdata & ~DW'(2);
                default:  ;
            endcase
        end
    end

    // Registered outputs and vector, recomputed every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o      <= 1'b0;
            crit_irq_o <= 1'b0;
            vec_q      <= '0;
        end else begin
            irq_o      <= |pend_nrm;
            crit_irq_o <= |pend_crit;
            vec_q      <= vec_c;
        end
    end

    // Read multiplexer over the register offsets.
    always_comb begin
        case (addr)
            OFF_CLR, OFF_SET: rd_mux = st_q;
            OFF_EN:   rd_mux = en_q;
            OFF_CRIT: rd_mux = crit_q;
            OFF_POL:  rd_mux = pol_q;
            OFF_TRIG: rd_mux = trig_q;
            OFF_MASK: rd_mux = st_q & en_q;
            OFF_VEC:  rd_mux = VEC_EN ? vec_q : '0;
            OFF_VCFG: rd_mux = VEC_EN ? vcfg_q : '0;
            default:  rd_mux = '0;
        endcase
    end

    // Read data register, loaded one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

endmodule

// File: rtl/steer_intc_chk.sv
// Module: property checker for steer_intc, attached by bind. Observes the
// access port, outputs and internal register state; drives nothing.
module steer_intc_chk
    import steer_intc_pkg::*;
#(
    parameter int DW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic             wr_en,
    input logic [OFF_W-1:0] addr,
    input logic [DW-1:0]    wdata,
    input logic [DW-1:0]    rdata,
    input logic             irq_o,
    input logic             crit_irq_o,
    input logic [DW-1:0]    st_q,
    input logic [DW-1:0]    en_q,
    input logic [DW-1:0]    crit_q,
    input logic [DW-1:0]    pol_q,
    input logic [DW-1:0]    trig_q,
    input logic [DW-1:0]    vcfg_q,
    input logic [DW-1:0]    vec_q,
    input logic [DW-1:0]    adj
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (st_q == '0 && en_q == '0 && crit_q == '0 && vcfg_q == '0
                    && vec_q == '0 && !irq_o && !crit_irq_o));

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(st_q) & $past(trig_q))
                   & ~(($past(wr_en) && $past(addr) == OFF_CLR) ? $past(wdata) : '0))
                  & ~st_q) == '0);

    // R5
    lvl_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CLR) |=> (($past(adj & ~trig_q)) & ~st_q) == '0);

    // R8
    crit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crit_irq_o) |-> $past(st_q != '0));

    // R9
    ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFF_MASK || addr == OFF_VEC)) |=>
            ($stable(en_q) && $stable(crit_q) && $stable(pol_q)
             && $stable(trig_q) && $stable(vcfg_q)));

    // R12
    vec_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !crit_irq_o |-> vec_q == '0);

    // R13
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFF_EN) |=> rdata == $past(en_q));

endmodule

bind steer_intc steer_intc_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .irq_o      (irq_o),
    .crit_irq_o (crit_irq_o),
    .st_q       (st_q),
    .en_q       (en_q),
    .crit_q     (crit_q),
    .pol_q      (pol_q),
    .trig_q     (trig_q),
    .vcfg_q     (vcfg_q),
    .vec_q      (vec_q),
    .adj        (adj)
);

// File: tb/steer_intc_test.sv
// Bench: seeded random stimulus plus directed corners against a
// transaction-level reference model of the controller.
module steer_intc_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] src_i = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq_o;
    logic          crit_irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state, register bit order
    logic [DW-1:0] m_st, m_en, m_cr, m_pol, m_tr, m_vc, m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    steer_intc uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .irq_o      (irq_o),
        .crit_irq_o (crit_irq_o)
    );

    function automatic logic [DW-1:0] to_bits(input logic [DW-1:0] s);
        logic [DW-1:0] b;
        for (int n = 0; n < DW; n++) b[DW-1-n] = s[n];
        return b;
    endfunction

    function automatic logic [DW-1:0] exp_vec(input logic [DW-1:0] p, input logic [DW-1:0] c);
        int idx;
        idx = -1;
        if (p == '0) return '0;
        if (!c[0]) begin
            for (int i = 0; i < DW; i++) if (p[i] && idx < 0) idx = i;
            return (c & 32'hFFFF_FFFC) + 32'(idx * 512);
        end
        for (int i = DW-1; i >= 0; i--) if (p[i] && idx < 0) idx = i;
        return (c & 32'hFFFF_FFFC) + 32'((31 - idx) * 512);
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [DW-1:0] a, rs, ch;
        a  = to_bits(src_i) ^ m_pol;
        rs = a & ~m_prev;
        ch = a ^ m_prev;
        m_st = m_st | (rs & m_tr);
        m_st = (m_st & ~(ch & ~m_tr)) | (a & ch & ~m_tr);
        m_prev = a;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            4'd0: m_st = (m_st & ~d) | (m_prev & ~m_tr);
            4'd1: m_st = m_st | d;
            4'd2: m_en = d;
            4'd3: m_cr = d;
            4'd4: m_pol = d;
            4'd5: m_tr = d;
            4'd8: m_vc = d & 32'hFFFF_FFFD;
            default: ;
        endcase
        model_step();
        settle();
    endtask

    task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic drive_src(input logic [DW-1:0] s);
        @(negedge clk);
        src_i = s;
        settle();
        model_step();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_st = '0; m_en = '0; m_cr = '0; m_pol = '0; m_tr = '0; m_vc = '0; m_prev = '0;
        settle();
    endtask

    task automatic check_all(input string tag);
        logic [DW-1:0] d;
        rd(4'd0, d); chk({tag, " R6 status"}, d, m_st);
        rd(4'd6, d); chk({tag, " R9 masked"}, d, m_st & m_en);
        rd(4'd7, d); chk({tag, " R10 vector"}, d, exp_vec(m_st & m_en & m_cr, m_vc));
        chk({tag, " R8 irq"}, {31'd0, irq_o}, {31'd0, |(m_st & m_en & ~m_cr)});
        chk({tag, " R8 crit"}, {31'd0, crit_irq_o}, {31'd0, |(m_st & m_en & m_cr)});
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'h5EED_1234));
        do_reset();

        // R1 reset state, R13 one-cycle read
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            chk($sformatf("R1 R13 reset read off %0d", a), d, '0);
        end
        chk("R1 outputs low", {30'd0, irq_o, crit_irq_o}, '0);

        // R2 mapping, R4 level tracking
        wr(4'd2, 32'hFFFF_FFFF);
        drive_src(32'h0000_0001);
        rd(4'd0, d); chk("R2 line0 at msb", d, 32'h8000_0000);
        chk("R8 normal output", {31'd0, irq_o}, 32'd1);
        drive_src(32'h8000_0000);
        rd(4'd0, d); chk("R4 level falls / R2 line31 at lsb", d, 32'h0000_0001);
        drive_src('0);

        // R3 edge capture holds after input falls
        wr(4'd5, 32'hFFFF_FFFF);
        drive_src(32'h0000_0020);
        drive_src('0);
        rd(4'd0, d); chk("R3 edge held", d, 32'h0400_0000);
        wr(4'd0, 32'h0400_0000);
        rd(4'd0, d); chk("R5 edge cleared", d, '0);

        // R5 level source re-asserted after clear
        wr(4'd5, '0);
        drive_src(32'h0000_0008);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, d); chk("R5 level reassert", d, 32'h1000_0000);
        drive_src('0);

        // R7 polarity inverts line 7 (bit 24)
        wr(4'd4, 32'h0100_0000);
        rd(4'd0, d); chk("R7 active low", d, 32'h0100_0000);
        wr(4'd4, '0);

        // R6 set alias, readable at offset 1
        wr(4'd1, 32'h00F0_0000);
        rd(4'd1, d); chk("R6 set alias", d, 32'h00F0_0000);

        // R9 read-only and undefined offsets
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd2, d); chk("R9 enable unchanged", d, 32'hFFFF_FFFF);
        rd(4'd0, d); chk("R9 status unchanged", d, 32'h00F0_0000);
        rd(4'd12, d); chk("R9 undefined reads 0", d, '0);
        rd(4'd7, d); chk("R12 vector 0 when none critical", d, '0);

        // R10/R11/R12 vector
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd1, 32'h1000_0800);     // bits 28 and 11
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd8, 32'h0001_0000);
        rd(4'd7, d); chk("R10 lowest index", d, 32'h0001_1600);
        chk("R8 critical output", {31'd0, crit_irq_o}, 32'd1);
        chk("R8 normal off when all critical", {31'd0, irq_o}, 32'd0);
        wr(4'd8, 32'h0001_0001);
        rd(4'd7, d); chk("R11 highest index", d, 32'h0001_0600);
        wr(4'd8, 32'hFFFF_FFFF);
        rd(4'd8, d); chk("R12 cfg bit1 forced 0", d, 32'hFFFF_FFFD);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd7, d); chk("R12 vector 0 after clear", d, '0);

        // random phase
        do_reset();
        for (int it = 0; it < 300; it++) begin
            logic [DW-1:0] r;
            int op;
            op = int'($urandom_range(0, 9));
            r = $urandom;
            case (op)
                0, 1, 2: drive_src(src_i ^ (r & $urandom & $urandom));
                3: wr(4'd2, r);
                4: wr(4'd3, r);
                5: wr(4'd4, m_pol ^ (r & $urandom & $urandom));
                6: wr(4'd5, r);
                7: wr(4'd0, r);
                8: wr(4'd1, r & $urandom & $urandom);
                default: wr(4'd8, r);
            endcase
            check_all($sformatf("rand %0d", it));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule